// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block is an 8-bit up-counting timer built around one external capture input. In capture mode, a rising edge on that input copies the running count into a rising-edge capture register. A falling edge copies it into a separate falling-edge capture register. The counter can be set to clear on either edge, on both edges, or on neither. When the count wraps, one of two overflow flags is set, chosen by the level of the input at that moment.

With capture disabled, the block behaves as a free-running interval counter. In that mode every wrap is recorded as a low-input overflow. A free-running prescaler sets the count rate, and a 2-bit field selects one of four divide ratios. Software reaches the block through a small register port. A single interrupt line combines a sticky request flag with an enable bit.

Top module: `capt_timer`

## Requirements
- R1: A synchronous reset sets the setup register, the control register, the counter and both capture registers to 0x00, and restarts the prescaler at zero.
- R2: A 6-bit prescaler counts every clock from zero after reset. The counter advances by one in each cycle where the selected low prescaler bits are all ones. Setup bits [1:0] select the ratio: 00 = 64, 01 = 32, 10 = 8, 11 = 2. The first increment after reset therefore comes on the 64th clock.
- R3: The capture input passes through two synchronizing flops. A rising edge copies the count into the rising-edge capture register, and a falling edge copies it into the falling-edge capture register.
- R4: Setup bits [3:2] control clearing. Bit 2 clears the counter on a rising edge and bit 3 clears it on a falling edge, so 11 clears on both and 00 clears on neither. A clear takes priority over an increment in the same cycle. A capture on the same edge stores the count from before the clear.
- R5: A wrap from 0xFF to 0x00 sets setup bit 7 if the gated input is high, and setup bit 6 if it is low.
- R6: Control bit 2 is the interrupt-request flag. It is set by a rising edge when setup bit 4 is 1, and by a falling edge when setup bit 4 is 0.
- R7: When setup bit 5 is 1, a wrap also sets the interrupt-request flag.
- R8: The interrupt output is high exactly when the request flag and control bit 1 are both 1.
- R9: Setup bits 7:6 and control bit 2 are sticky. Writing 0 to one of them clears it, and writing 1 leaves it unchanged. If the flag's set event falls in the same cycle as a clearing write, the flag ends up set.
- R10: Control bit 0 enables capture. While it is 0, the synchronized input is treated as low: it causes no capture and no clear, and every wrap sets setup bit 6. Changing this bit while the input is high produces an edge: setting it gives a rising capture, and clearing it gives a falling capture.
- R11: The register addresses are 0 = setup, 1 = control, 2 = count, 3 = rising capture, 4 = falling capture. Addresses 2 to 4 are read-only, and writes to them are ignored. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| capIn | input | 1 | External capture input (asynchronous) |
| irq | output | 1 | Interrupt request |

## Verification
The in-module properties check the following on every cycle:
- the counter steps, holds or clears exactly as the strobes say;
- capture registers take the pre-edge count;
- ticks never fall on two adjacent cycles;
- wraps set the overflow flag that matches the input level;
- a selected edge raises the request flag;
- the flags stay set until cleared;
- no edge appears while capture has been off for two cycles.

Only the bench's scenarios show the following:
- the absolute count rate of each divide ratio;
- the captured values relative to a reference model of the counter;
- edge-to-clear selection;
- the spurious edges from toggling the enable;
- that writes to read-only addresses are ignored.

// File: rtl/capt_timer_pkg.sv
package capt_timer_pkg;

  // Strobes from control to datapath, each valid for one clock.
  typedef struct packed {
    logic tick;     // counter increment enable
    logic clear;    // counter clear (wins over tick)
    logic capRise;  // load rising-edge capture register
    logic capFall;  // load falling-edge capture register
  } tmr_strobe_t;

  localparam int unsigned ADDR_SETUP = 0;
  localparam int unsigned ADDR_CTL   = 1;
  localparam int unsigned ADDR_COUNT = 2;
  localparam int unsigned ADDR_RISE  = 3;
  localparam int unsigned ADDR_FALL  = 4;

endpackage

// File: rtl/capt_timer_dp.sv
module capt_timer_dp
  import capt_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_strobe_t       strobe,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capRiseVal,
  output logic [CNT_W-1:0]  capFallVal
);

  localparam int unsigned NUM_CAP = 2;

  logic [NUM_CAP-1:0] capLoad;
  logic [CNT_W-1:0]   capQ [NUM_CAP];

  assign capLoad = {strobe.capFall, strobe.capRise};

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (strobe.clear) count <= '0;
    else if (strobe.tick)  count <= count + 1'b1;
  end

  // One capture slot per edge polarity; each stores the pre-clear count.
  for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)             capQ[g] <= '0;
      else if (capLoad[g]) capQ[g] <= count;
    end
  end

  assign capRiseVal = capQ[0];
  assign capFallVal = capQ[1];

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.clear |=> (count == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && !strobe.clear) |=> (count == CNT_W'($past(count) + 1'b1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!strobe.tick && !strobe.clear) |=> (count == $past(count)));

  p_cap_rise_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.capRise |=> (capRiseVal == $past(count)));

  p_cap_fall_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.capFall |=> (capFallVal == $past(count)));

endmodule

// File: rtl/capt_timer_ctrl.sv
module capt_timer_ctrl
  import capt_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned PRE_W   = 6,
  parameter int unsigned DIV_LOG [4] = '{6, 5, 3, 1}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              capIn,
  output logic              irq,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capRiseVal,
  input  logic [CNT_W-1:0]  capFallVal,
  output tmr_strobe_t       strobe
);

  localparam int unsigned SYNC_N = 2;

  // Setup register fields
  logic [1:0] clkSel;
  logic       clrOnRise, clrOnFall;
  logic       edgeSel;     // 1: rising edge requests, 0: falling
  logic       ovfIntEn;
  logic       ovfHi, ovfLo;
  // Control register fields
  logic       capEn, intEn, irqFlag;

  // Input synchronizer and edge detect
  logic [SYNC_N-1:0] syncQ;
  logic              gatedLvl, prevLvl, riseEv, fallEv;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_N-2:0], capIn};
      prevLvl <= gatedLvl;
    end
  end

  assign gatedLvl = syncQ[SYNC_N-1] & capEn;
  assign riseEv   = gatedLvl & ~prevLvl;
  assign fallEv   = ~gatedLvl & prevLvl;

  // Prescaler with per-selection tick masks
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] maskTab [4];
  logic [PRE_W-1:0] selMask;
  logic             tick;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign maskTab[g] = PRE_W'((64'd1 << DIV_LOG[g]) - 64'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) preCnt <= '0;
    else     preCnt <= preCnt + 1'b1;
  end

  assign selMask = maskTab[clkSel];
  assign tick    = (preCnt & selMask) == selMask;

  // Events
  logic clearEv, wrapEv;
  assign clearEv = (clrOnRise & riseEv) | (clrOnFall & fallEv);
  assign wrapEv  = tick & ~clearEv & (count == '1);

  assign strobe.tick    = tick;
  assign strobe.clear   = clearEv;
  assign strobe.capRise = riseEv;
  assign strobe.capFall = fallEv;

  // Register writes
  logic wrSetup, wrCtl, irqSet;
  assign wrSetup = regWrEn && (regAddr == ADDR_W'(ADDR_SETUP));
  assign wrCtl   = regWrEn && (regAddr == ADDR_W'(ADDR_CTL));
  assign irqSet  = (edgeSel ? riseEv : fallEv) | (ovfIntEn & wrapEv);

  always_ff @(posedge clk) begin
    if (rst) begin
      clkSel    <= '0;
      clrOnRise <= 1'b0;
      clrOnFall <= 1'b0;
      edgeSel   <= 1'b0;
      ovfIntEn  <= 1'b0;
      ovfHi     <= 1'b0;
      ovfLo     <= 1'b0;
      capEn     <= 1'b0;
      intEn     <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (wrSetup) begin
        clkSel    <= regWrData[1:0];
        clrOnRise <= regWrData[2];
        clrOnFall <= regWrData[3];
        edgeSel   <= regWrData[4];
        ovfIntEn  <= regWrData[5];
      end
      if (wrCtl) begin
        capEn <= regWrData[0];
        intEn <= regWrData[1];
      end
      // Sticky flags: write 0 clears, set event wins.
      ovfHi   <= (ovfHi & ~(wrSetup & ~regWrData[7])) | (wrapEv & gatedLvl);
      ovfLo   <= (ovfLo & ~(wrSetup & ~regWrData[6])) | (wrapEv & ~gatedLvl);
      irqFlag <= (irqFlag & ~(wrCtl & ~regWrData[2])) | irqSet;
    end
  end

  assign irq = irqFlag & intEn;

  // Read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_SETUP): regRdData = DATA_W'({ovfHi, ovfLo, ovfIntEn, edgeSel,
                                                clrOnFall, clrOnRise, clkSel});
      ADDR_W'(ADDR_CTL):   regRdData = DATA_W'({irqFlag, intEn, capEn});
      ADDR_W'(ADDR_COUNT): regRdData = DATA_W'(count);
      ADDR_W'(ADDR_RISE):  regRdData = DATA_W'(capRiseVal);
      ADDR_W'(ADDR_FALL):  regRdData = DATA_W'(capFallVal);
      default:             regRdData = '0;
    endcase
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_ovf_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (wrapEv && gatedLvl) |=> ovfHi);

  p_ovf_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (wrapEv && !gatedLvl) |=> ovfLo);

  p_edge_req_r6: assert property (@(posedge clk) disable iff (rst)
    ((edgeSel && riseEv) || (!edgeSel && fallEv)) |=> irqFlag);

  p_ovf_req_r7: assert property (@(posedge clk) disable iff (rst)
    (ovfIntEn && wrapEv) |=> irqFlag);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irqFlag && !(wrCtl && !regWrData[2])) |=> irqFlag);

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!capEn && $past(!capEn)) |-> (!riseEv && !fallEv));

endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import capt_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              capIn,
  output logic              irq
);

  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] count, capRiseVal, capFallVal;

  capt_timer_ctrl #(
    .CNT_W (CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .capIn     (capIn),
    .irq       (irq),
    .count     (count),
    .capRiseVal(capRiseVal),
    .capFallVal(capFallVal),
    .strobe    (strobe)
  );

  capt_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .count     (count),
    .capRiseVal(capRiseVal),
    .capFallVal(capFallVal)
  );

endmodule

// File: tb/capt_timer_tb_top.sv
`timescale 1ns/1ps
module capt_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       capIn = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;  // 200 MHz

  capt_timer dut_i (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .capIn(capIn), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // ---------------- reference model from the requirements ----------------
  logic [5:0] mPre;
  logic [1:0] mS;
  logic       mPrev;
  logic [7:0] mCnt, mCapR, mCapF, mMode;
  logic [2:0] mCtl;
  logic       lvl, rise, fall, tick, clr, wrap, wM, wC;
  logic [5:0] mask;
  logic [7:0] nMode;
  logic [2:0] nCtl;

  always @(posedge clk) begin
    if (rst) begin
      mPre <= '0; mS <= '0; mPrev <= 1'b0; mCnt <= '0;
      mCapR <= '0; mCapF <= '0; mMode <= '0; mCtl <= '0;
    end else begin
      lvl  = mS[1] & mCtl[0];
      rise = lvl & ~mPrev;
      fall = ~lvl & mPrev;
      case (mMode[1:0])
        2'b00: mask = 6'd63;
        2'b01: mask = 6'd31;
        2'b10: mask = 6'd7;
        default: mask = 6'd1;
      endcase
      tick = (mPre & mask) == mask;
      clr  = (mMode[2] & rise) | (mMode[3] & fall);
      wrap = tick & ~clr & (mCnt == 8'hFF);
      mPre  <= mPre + 1'b1;
      mS    <= {mS[0], capIn};
      mPrev <= lvl;
      if (clr) mCnt <= '0; else if (tick) mCnt <= mCnt + 1'b1;
      if (rise) mCapR <= mCnt;
      if (fall) mCapF <= mCnt;
      wM = regWrEn && regAddr == 3'd0;
      wC = regWrEn && regAddr == 3'd1;
      nMode = mMode;
      if (wM) nMode = {mMode[7] & regWrData[7], mMode[6] & regWrData[6], regWrData[5:0]};
      if (wrap & lvl)  nMode[7] = 1'b1;
      if (wrap & ~lvl) nMode[6] = 1'b1;
      nCtl = mCtl;
      if (wC) nCtl = {mCtl[2] & regWrData[2], regWrData[1:0]};
      if ((mMode[4] & rise) | (~mMode[4] & fall) | (mMode[5] & wrap)) nCtl[2] = 1'b1;
      mMode <= nMode;
      mCtl  <= nCtl;
    end
  end

  function automatic logic [7:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return mMode;
      3'd1: return {5'd0, mCtl};
      3'd2: return mCnt;
      3'd3: return mCapR;
      3'd4: return mCapF;
      default: return 8'h00;
    endcase
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    int         kind;   // 0: read data, 1: irq pin
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  initial begin
    item_t it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        act = (it.kind == 0) ? regRdData : {7'd0, irq};
        checks++;
        if (act !== it.exp) begin
          errors++;
          if (it.kind == 0)
            $display("FAIL %s: addr %0d got %02h expected %02h", it.tag, it.addr, act, it.exp);
          else
            $display("FAIL %s: irq got %0d expected %0d", it.tag, act[0], it.exp[0]);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk(input logic [2:0] a, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    push(0, a, expRd(a), tag);
    @(negedge clk);
  endtask

  task automatic chkLit(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    push(0, a, e, tag);
    @(negedge clk);
  endtask

  task automatic chkIrq(input string tag);
    @(posedge clk); #1;
    push(1, 3'd0, {7'd0, mCtl[2] & mCtl[1]}, tag);
    @(negedge clk);
  endtask

  task automatic chkIrqLit(input logic e, input string tag);
    @(posedge clk); #1;
    push(1, 3'd0, {7'd0, e}, tag);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic setIn(input logic v);
    @(posedge clk); #1;
    capIn = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 / R11: reset values
    chkLit(3'd0, 8'h00, "R1 setup");
    chkLit(3'd1, 8'h00, "R1 ctl");
    chkLit(3'd2, 8'h00, "R1 count");
    chkLit(3'd3, 8'h00, "R1 rise cap");
    chkLit(3'd4, 8'h00, "R1 fall cap");
    chkLit(3'd7, 8'h00, "R11 unused addr");
    chkIrqLit(1'b0, "R1 irq");

    // R2: rates
    idle(70);
    chk(3'd2, "R2 div64");
    wr(3'd0, 8'h03); idle(20); chk(3'd2, "R2 div2");
    wr(3'd0, 8'h02); idle(30); chk(3'd2, "R2 div8");
    wr(3'd0, 8'h01); idle(40); chk(3'd2, "R2 div32");

    // R3: captures
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h01);
    idle(10);
    setIn(1'b1); idle(5); chk(3'd3, "R3 rise cap"); chk(3'd2, "R3 count");
    idle(17);
    setIn(1'b0); idle(5); chk(3'd4, "R3 fall cap");

    // R4: clear control
    wr(3'd0, 8'h06); idle(40);
    setIn(1'b1); idle(4); chk(3'd2, "R4 clear on rise"); chk(3'd3, "R4 pre-clear cap");
    idle(20);
    setIn(1'b0); idle(4); chk(3'd2, "R4 no clear on fall");
    wr(3'd0, 8'h0A); setIn(1'b1); idle(20);
    setIn(1'b0); idle(4); chk(3'd2, "R4 clear on fall"); chk(3'd4, "R4 fall cap");
    wr(3'd0, 8'h0E); idle(25);
    setIn(1'b1); idle(4); chk(3'd2, "R4 both rise");
    idle(25);
    setIn(1'b0); idle(4); chk(3'd2, "R4 both fall");

    // R6 / R8: edge request and irq gating
    wr(3'd0, 8'h12); wr(3'd1, 8'h03);
    setIn(1'b1); idle(5);
    chk(3'd1, "R6 rise request"); chkIrq("R8 irq on");
    wr(3'd1, 8'h03); chk(3'd1, "R9 clear flag");
    setIn(1'b0); idle(5); chk(3'd1, "R6 fall ignored");
    wr(3'd0, 8'h02); wr(3'd1, 8'h01);
    setIn(1'b1); idle(5); setIn(1'b0); idle(5);
    chk(3'd1, "R6 fall request"); chkIrq("R8 irq masked");

    // R9: write 1 keeps, write 0 clears
    wr(3'd1, 8'h05); chk(3'd1, "R9 write one keeps");
    wr(3'd1, 8'h01); chk(3'd1, "R9 write zero clears");

    // R5 / R10: interval mode, input high but gated off
    wr(3'd1, 8'h00); setIn(1'b1);
    wr(3'd0, 8'h03); idle(600);
    chk(3'd0, "R5 low overflow");
    chkLit(3'd0, 8'h43, "R10 interval overflow low");

    // R10 spurious rise by enabling with input high, then R5 high overflow
    wr(3'd1, 8'h01); idle(4);
    chk(3'd3, "R10 spurious rise cap");
    wr(3'd0, 8'h03); idle(600);
    chkLit(3'd0, 8'h83, "R5 high overflow");

    // R7: overflow request
    wr(3'd0, 8'h23); wr(3'd1, 8'h03); idle(600);
    chk(3'd1, "R7 overflow request"); chkIrq("R7 irq");

    // R10: disable with input high gives falling capture, then no captures
    wr(3'd1, 8'h00); idle(4);
    chk(3'd4, "R10 spurious fall cap");
    setIn(1'b0); idle(6); setIn(1'b1); idle(6); setIn(1'b0); idle(6);
    chk(3'd3, "R10 no rise cap"); chk(3'd4, "R10 no fall cap");

    // R11: read-only addresses ignore writes
    wr(3'd2, 8'h55); chk(3'd2, "R11 count ro");
    wr(3'd3, 8'hAA); chk(3'd3, "R11 rise ro");
    wr(3'd4, 8'h5A); chk(3'd4, "R11 fall ro");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got no completion, expected completion");
      summary();
      $finish;
    end
  end

endmodule